// File: doc/BRIEF.md
# Split-Access Hypervisor Configuration Register

This block stores a 64-bit hypervisor configuration word. Software can update it in three ways: the whole word at once, or either 32-bit half through a narrower accessor. A half update is merged with the untouched half, and the merged word then goes through the same commit and change-detection logic as a full update. Whenever a committed update changes any of the translation-affecting control bits, the block raises a one-cycle request to flush the translation cache. Those bits are the stage-2 enable, the page-table-walk protection and the default-cacheable control.

Two parameters select build variants. `HAS_HYP` = 0 gives a configuration with no hypervisor level. In that build the register reads as zero, ignores every write and never requests a flush. `HAS_HI_ACCESS` = 0 gives a build without the upper-half accessor. In that build high-half accesses are not decoded, while full and low-half accesses still work. Reads are combinational from the stored word. Access-privilege checking and the translation cache itself belong to neighbouring blocks.

Top module: `hyp_ctrl_reg`

## Requirements
- R1: After reset the stored word is zero, every read returns zero and `flush_req` is low.
- R2: A write with `wr_sel` = 2'b00 replaces all 64 bits with `wr_data`; the new value is visible at the read port after the next rising clock edge.
- R3: A write with `wr_sel` = 2'b01 replaces bits 31:0 with `wr_data[31:0]` and keeps bits 63:32.
- R4: A write with `wr_sel` = 2'b10 replaces bits 63:32 with `wr_data[31:0]` and keeps bits 31:0.
- R5: When a committed write changes bit 0 (stage-2 enable), bit 2 (walk protection) or bit 12 (default cacheable), `flush_req` is high for exactly the one cycle after that clock edge.
- R6: A committed write that leaves bits 0, 2 and 12 unchanged raises no flush. This holds for full writes and for half writes alike.
- R7: The stored word does not change in cycles with `wr_en` low, and a write with `wr_sel` = 2'b11 is ignored.
- R8: `rd_sel` = 2'b00 returns the full word. 2'b01 returns bits 31:0, zero-extended. 2'b10 returns bits 63:32 in `rd_data[31:0]`, zero-extended. 2'b11 returns zero.
- R9: With `HAS_HI_ACCESS` = 0, high-half writes are ignored and high-half reads return zero.
- R10: With `HAS_HYP` = 0, all reads return zero, writes are discarded and `flush_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write access: full, low half, high half, none |
| wr_data | input | 64 | Write data (half writes use bits 31:0) |
| rd_sel | input | 2 | Read access: full, low half, high half, none |
| rd_data | output | 64 | Read data |
| flush_req | output | 1 | One-cycle translation-cache flush request |

## Verification
The assertions assume that `wr_en`, `wr_sel` and `wr_data` are known at every rising edge after reset. They also assume that reset is held for at least one edge, because the flush-cause property compares against the value from the previous cycle. The stimulus meets both assumptions: inputs change only on falling edges, reset is held for several cycles, and idle cycles drive the strobe low with defined selects. Back-to-back writes are also applied, so the flush pulse is checked both when it repeats and when it returns to zero.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [1:0] {
        ACC_FULL = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_NONE = 2'b11
    } acc_sel_e;

    localparam int unsigned REG_W  = 64;
    localparam int unsigned HALF_W = REG_W / 2;

    typedef struct packed {
        logic [REG_W-1:0] val;
        logic             flush;
    } hcr_state_t;

endpackage

// File: rtl/hcr_merge.sv
module hcr_merge
    import hcr_pkg::*;
#(
    parameter bit HI_EN    = 1'b1,
    parameter bit WR_ALLOW = 1'b1
) (
    input  logic [REG_W-1:0] old_val,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] new_val,
    output logic             commit
);
    logic hi_ok;

    generate
        if (HI_EN) begin : g_hi
            assign hi_ok = 1'b1;
        end else begin : g_no_hi
            assign hi_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        new_val = old_val;
        commit  = 1'b0;
        if (wr_en && WR_ALLOW) begin
            case (acc_sel_e'(wr_sel))
                ACC_FULL: begin
                    new_val = wr_data;
                    commit  = 1'b1;
                end
                ACC_LO: begin
                    new_val = {old_val[REG_W-1:HALF_W], wr_data[HALF_W-1:0]};
                    commit  = 1'b1;
                end
                ACC_HI: begin
                    if (hi_ok) begin
                        new_val = {wr_data[HALF_W-1:0], old_val[HALF_W-1:0]};
                        commit  = 1'b1;
                    end
                end
                default: begin
                    new_val = old_val;
                    commit  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hcr_change_det.sv
module hcr_change_det
    import hcr_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK = '0
) (
    input  logic [REG_W-1:0] old_val,
    input  logic [REG_W-1:0] new_val,
    input  logic             commit,
    output logic             hit
);
    logic [REG_W-1:0] diff;

    always_comb begin
        diff = (old_val ^ new_val) & MASK;
        hit  = commit && (diff != '0);
    end
endmodule

// File: rtl/hcr_read_mux.sv
module hcr_read_mux
    import hcr_pkg::*;
#(
    parameter bit HI_EN  = 1'b1,
    parameter bit RD_EN  = 1'b1
) (
    input  logic [REG_W-1:0] cur_val,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] sel_val;

    always_comb begin
        case (acc_sel_e'(rd_sel))
            ACC_FULL: sel_val = cur_val;
            ACC_LO:   sel_val = {{HALF_W{1'b0}}, cur_val[HALF_W-1:0]};
            ACC_HI:   sel_val = HI_EN ? {{HALF_W{1'b0}}, cur_val[REG_W-1:HALF_W]}
                                      : '0;
            default:  sel_val = '0;
        endcase
    end

    generate
        if (RD_EN) begin : g_rd
            assign rd_data = sel_val;
        end else begin : g_rd_zero
            assign rd_data = '0;
        end
    endgenerate
endmodule

// File: rtl/hyp_ctrl_reg.sv
module hyp_ctrl_reg
    import hcr_pkg::*;
#(
    parameter bit          HAS_HYP       = 1'b1,
    parameter bit          HAS_HI_ACCESS = 1'b1,
    parameter int unsigned S2_EN_BIT     = 0,
    parameter int unsigned WALK_PROT_BIT = 2,
    parameter int unsigned DEF_CACHE_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              flush_req
);
    localparam logic [REG_W-1:0] FLUSH_MASK = (REG_W'(1) << S2_EN_BIT)
                                            | (REG_W'(1) << WALK_PROT_BIT)
                                            | (REG_W'(1) << DEF_CACHE_BIT);

    hcr_state_t       state_d, state_q;
    logic [REG_W-1:0] merged;
    logic             commit;
    logic             flush_hit;
    logic [REG_W-1:0] val_q;

    hcr_merge #(
        .HI_EN    (HAS_HI_ACCESS),
        .WR_ALLOW (HAS_HYP)
    ) merge_i (
        .old_val (state_q.val),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .new_val (merged),
        .commit  (commit)
    );

    hcr_change_det #(
        .MASK (FLUSH_MASK)
    ) det_i (
        .old_val (state_q.val),
        .new_val (merged),
        .commit  (commit),
        .hit     (flush_hit)
    );

    always_comb begin
        state_d       = state_q;
        state_d.flush = flush_hit;
        if (commit) begin
            state_d.val = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign val_q     = state_q.val;
    assign flush_req = state_q.flush;

    hcr_read_mux #(
        .HI_EN (HAS_HI_ACCESS),
        .RD_EN (HAS_HYP)
    ) rd_i (
        .cur_val (val_q),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker
    import hcr_pkg::*;
#(
    parameter bit               HAS_HYP = 1'b1,
    parameter logic [REG_W-1:0] MASK    = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [REG_W-1:0] rd_data,
    input logic             flush_req,
    input logic [REG_W-1:0] val_q
);
    AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(wr_en)); // R5

    AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (((val_q ^ $past(val_q)) & MASK) != '0)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(val_q)); // R7

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b01) |=> (val_q[REG_W-1:HALF_W] == $past(val_q[REG_W-1:HALF_W]))); // R3

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b10) |=> (val_q[HALF_W-1:0] == $past(val_q[HALF_W-1:0]))); // R4

    generate
        if (!HAS_HYP) begin : g_nohyp
            AST_NOHYP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_data == '0) && !flush_req); // R10
        end
    endgenerate
endmodule

bind hyp_ctrl_reg hcr_checker #(
    .HAS_HYP (HAS_HYP),
    .MASK    (FLUSH_MASK)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .rd_data   (rd_data),
    .flush_req (flush_req),
    .val_q     (val_q)
);

// File: tb/hyp_ctrl_reg_tb_top.sv
module hyp_ctrl_reg_tb_top;
    localparam logic [63:0] FMASK = 64'h0000_0000_0000_1005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'b00;
    logic [63:0] rd_main, rd_v7, rd_nohyp;
    logic        fl_main, fl_v7, fl_nohyp;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_main = '0;
    logic [63:0] m_v7 = '0;

    always #10 clk = ~clk;

    hyp_ctrl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_main), .flush_req(fl_main));

    hyp_ctrl_reg #(.HAS_HI_ACCESS(1'b0)) dut_v7_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_v7), .flush_req(fl_v7));

    hyp_ctrl_reg #(.HAS_HYP(1'b0)) dut_nohyp_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_nohyp), .flush_req(fl_nohyp));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] next_val(input logic [63:0] old, input logic [1:0] sel,
                                             input logic [63:0] d, input bit hi_ok);
        case (sel)
            2'b00:   return d;
            2'b01:   return {old[63:32], d[31:0]};
            2'b10:   return hi_ok ? {d[31:0], old[31:0]} : old;
            default: return old;
        endcase
    endfunction

    function automatic logic [63:0] read_exp(input logic [63:0] v, input logic [1:0] sel,
                                             input bit hi_ok);
        case (sel)
            2'b00:   return v;
            2'b01:   return {32'h0, v[31:0]};
            2'b10:   return hi_ok ? {32'h0, v[63:32]} : 64'h0;
            default: return 64'h0;
        endcase
    endfunction

    task automatic check_reads(input string tag);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check({tag, " R8 main"}, rd_main, read_exp(m_main, 2'(s), 1'b1));
            check({tag, " R9 v7"}, rd_v7, read_exp(m_v7, 2'(s), 1'b0));
            check({tag, " R10 nohyp"}, rd_nohyp, 64'h0);
        end
        rd_sel = 2'b00;
    endtask

    // One write, flush check one cycle later, reads, then flush low again.
    task automatic do_write(input string tag, input logic [1:0] sel, input logic [63:0] d);
        logic [63:0] nm, nv;
        logic em, ev;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        nm = next_val(m_main, sel, d, 1'b1);
        nv = next_val(m_v7, sel, d, 1'b0);
        em = (sel != 2'b11) && (((m_main ^ nm) & FMASK) != 0);
        ev = (sel != 2'b11) && (((m_v7 ^ nv) & FMASK) != 0);
        m_main = nm; m_v7 = nv;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
        check({tag, " R5/R6 flush main"}, {63'h0, fl_main}, {63'h0, em});
        check({tag, " R5/R6 flush v7"}, {63'h0, fl_v7}, {63'h0, ev});
        check({tag, " R10 flush nohyp"}, {63'h0, fl_nohyp}, 64'h0);
        check_reads(tag);
        @(negedge clk);
        check({tag, " R5 pulse ends"}, {63'h0, fl_main}, 64'h0);
    endtask

    task automatic t_reset;
        check_reads("R1 reset");
        check("R1 flush main", {63'h0, fl_main}, 64'h0);
    endtask

    task automatic t_full;
        do_write("R2 full set ctrl bits", 2'b00, 64'hDEAD_BEEF_0000_1005);
        do_write("R6 full same", 2'b00, 64'hDEAD_BEEF_0000_1005);
        do_write("R6 full other bit", 2'b00, 64'hDEAD_BEEF_0000_1025);
    endtask

    task automatic t_halves;
        do_write("R3 low clears bit2", 2'b01, 64'hFFFF_FFFF_1234_5001);
        do_write("R4 high", 2'b10, 64'h0000_0000_CAFE_F00D);
        do_write("R6 high no flush", 2'b10, 64'h0000_0000_0BAD_0001);
        do_write("R3 low bit12 off", 2'b01, 64'h0000_0000_1234_4001);
    endtask

    task automatic t_ignored;
        do_write("R7 sel none", 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        check_reads("R7 idle");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'b00; wr_data = 64'h0;
        @(negedge clk);
        wr_data = 64'h1;
        check("R5 b2b first", {63'h0, fl_main}, 64'h1);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
        check("R5 b2b second", {63'h0, fl_main}, 64'h1);
        @(negedge clk);
        check("R5 b2b ends", {63'h0, fl_main}, 64'h0);
        m_main = 64'h1;
        m_v7 = 64'h1;
        check_reads("R2 b2b");
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_halves();
        t_ignored();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule